// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters into NRZ asynchronous frames on a single serial line. A character is written into a holding register. As soon as the shift stage is free and the transmitter is enabled, the character moves into the shift stage, which frees the holding register for the next character. Each frame has a low start bit and 1 to 8 data bits sent least significant bit first. After the data come an optional address-marker bit, an optional even or odd parity bit, and one or two high stop bits. The line rests high between frames.

Bit timing comes from a 16-bit divisor value `d`. One bit lasts `(d+1)*8` clock cycles when `d` is nonzero, and 16 cycles when `d` is zero. The frame format and the divisor are captured at the moment a character enters the shift stage. Two flags report status: one says the holding register can take a character, the other says the whole transmit path is empty. An interrupt line follows the buffer-ready flag and has its own enable.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd`=1, `buf_ready`=1, `shift_empty`=1 and `irq`=0, and `txd` stays 1 whenever no frame is being sent.
- R2: A frame starts with one 0 bit. It is followed by `cfg_len_m1+1` data bits taken from `wr_data` in order bit 0 upward.
- R3: Every bit of a frame lasts exactly `(cfg_divisor+1)*8` clock cycles if `cfg_divisor` is nonzero, and exactly 16 cycles if it is zero.
- R4: With `cfg_par_en`=1 a parity bit is sent after the data bits and after any address bit. Counted over the data bits, the address bit (if present) and the parity bit, the number of ones is even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1.
- R5: With `cfg_addr_mode`=1 one bit follows the last data bit and comes before parity. Its value is the `wr_addr_bit` captured together with the character.
- R6: A frame ends with one stop bit of value 1, or two when `cfg_two_stop`=1.
- R7: An accepted write drops `buf_ready` on the next clock edge. If the transmitter is idle and enabled, the character moves to the shift stage on the following edge. That same edge raises `buf_ready` again and starts the start bit.
- R8: `shift_empty` is 1 only when the holding register is empty and no frame is in progress.
- R9: If a character is waiting when a frame's last stop bit ends, its start bit begins on the very next cycle, with no idle time.
- R10: A write while `buf_ready`=0 is ignored. The held character is neither replaced nor followed by the ignored one.
- R11: While `cfg_tx_en`=0 no new frame starts, even though writes are still accepted. A frame already in progress when the enable falls is completed.
- R12: `irq` equals `cfg_irq_en` AND `buf_ready`, with a one-cycle delay from a change of `cfg_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_divisor | input | DIV_W | Bit-period divisor |
| cfg_len_m1 | input | LEN_W | Data bit count minus one |
| cfg_par_en | input | 1 | Append parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_addr_mode | input | 1 | Insert address-marker bit |
| cfg_irq_en | input | 1 | Interrupt enable |
| wr_valid | input | 1 | Write strobe for a character |
| wr_data | input | DATA_W | Character to send |
| wr_addr_bit | input | 1 | Address-marker value for this character |
| txd | output | 1 | Serial output, idles high |
| buf_ready | output | 1 | Holding register can accept a character |
| shift_empty | output | 1 | Holding register and shift stage both empty |
| irq | output | 1 | Interrupt request |

## Verification
Any bad state in the holding register or the shift stage shows up at `txd` within one bit period. The fault then appears as a wrong bit value, a bit that is too long or too short, or a start bit that comes too early or too late. The bench checks every bit of every frame at its first and last cycle, so a one-cycle timing slip is caught. A stale holding-register flag shows on `buf_ready`, `shift_empty` or `irq` on the very next clock edge after a write or a transfer. A lost or overwritten character shows as a wrong frame, or as a frame that never comes, after the current frame ends.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
    logic addr_mode;
  } fmt_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 3;
  localparam logic [CNT_W-1:0] ZERO_LIM = CNT_W'(15);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;

  // (d+1)*8-1 == d*8+7
  assign lim_d = (divisor == '0) ? ZERO_LIM : {divisor, 3'b111};
  assign tick  = run && (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= ZERO_LIM;
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= lim_d;
    end else if (run) begin
      cnt_q <= (cnt_q == lim_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_abit,
  input  logic              take,
  output logic              full,
  output logic              full_next,
  output logic [DATA_W-1:0] data,
  output logic              abit
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              abit_q;
  logic              accept;

  assign accept    = wr_valid && !full_q;
  assign full_next = full_q ? !take : wr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
      abit_q <= 1'b0;
    end else begin
      full_q <= full_next;
      if (accept) begin
        data_q <= wr_data;
        abit_q <= wr_abit;
      end
    end
  end

  assign full = full_q;
  assign data = data_q;
  assign abit = abit_q;

  assert_full_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    full_q && wr_valid && !take |=> full_q && $stable(data_q) && $stable(abit_q));

  assert_take_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    take |-> full_q);

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              tick,
  input  logic [DATA_W-1:0] data,
  input  logic              abit,
  input  logic [LEN_W-1:0]  len_m1,
  input  fmt_t              fmt,
  output logic              busy,
  output logic              last,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 5;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               busy_q;
  logic [FRAME_W-1:0] frame_d;
  logic [CNT_W-1:0]   total_d;
  logic [CNT_W-1:0]   pos;
  logic               par;

  // parallel frame assembly: start, data LSB first, address, parity, stops
  always_comb begin
    frame_d    = '1;
    frame_d[0] = 1'b0;
    par        = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i <= int'(len_m1)) begin
        frame_d[i+1] = data[i];
        par          = par ^ data[i];
      end
    end
    pos = CNT_W'(len_m1) + CNT_W'(2);
    if (fmt.addr_mode) begin
      frame_d[pos] = abit;
      par          = par ^ abit;
      pos          = pos + 1'b1;
    end
    if (fmt.par_en) begin
      frame_d[pos] = par ^ fmt.par_odd;
      pos          = pos + 1'b1;
    end
    total_d = pos + (fmt.two_stop ? CNT_W'(2) : CNT_W'(1));
  end

  assign last = busy_q && tick && (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= frame_d;
      left_q <= total_d;
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      if (left_q == CNT_W'(1)) begin
        sh_q   <= '1;
        left_q <= '0;
        busy_q <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign txd  = sh_q[0];

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd);

  assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> !txd && busy_q);

  assert_bits_left_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> left_q != '0);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_tx_en,
  input  logic [DIV_W-1:0]  cfg_divisor,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cfg_addr_mode,
  input  logic              cfg_irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_addr_bit,
  output logic              txd,
  output logic              buf_ready,
  output logic              shift_empty,
  output logic              irq
);
  logic              buf_full;
  logic              buf_full_next;
  logic [DATA_W-1:0] buf_data;
  logic              buf_abit;
  logic              busy;
  logic              last;
  logic              tick;
  logic              load;
  logic              irq_q;
  fmt_t              fmt;

  assign fmt  = '{par_en: cfg_par_en, par_odd: cfg_par_odd,
                  two_stop: cfg_two_stop, addr_mode: cfg_addr_mode};
  assign load = buf_full && cfg_tx_en && (!busy || last);

  sertx_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_abit(wr_addr_bit), .take(load), .full(buf_full),
    .full_next(buf_full_next), .data(buf_data), .abit(buf_abit)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .start(load), .run(busy),
    .divisor(cfg_divisor), .tick(tick)
  );

  sertx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .tick(tick), .data(buf_data),
    .abit(buf_abit), .len_m1(cfg_len_m1), .fmt(fmt), .busy(busy),
    .last(last), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cfg_irq_en && !buf_full_next;
  end

  assign buf_ready   = !buf_full;
  assign shift_empty = !buf_full && !busy;
  assign irq         = irq_q;

  assert_empty_means_idle_R8: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> buf_ready && txd);

  assert_irq_needs_room_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> buf_ready);

  assert_disabled_no_start_R11: assert property (@(posedge clk) disable iff (rst)
    !cfg_tx_en && !busy |=> !busy);

  assert_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    last && buf_full && cfg_tx_en |=> busy && !txd);

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;
  localparam int DIV_W  = 16;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_tx_en = 1'b0;
  logic [DIV_W-1:0] cfg_divisor = '0;
  logic [LEN_W-1:0] cfg_len_m1 = '0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic cfg_addr_mode = 1'b0, cfg_irq_en = 1'b0;
  logic wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_addr_bit = 1'b0;
  logic txd, buf_ready, shift_empty, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [12:0] ef;
  int et;
  string etag [13];

  sertx_top #(.DIV_W(DIV_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_sertx_top (
    .clk(clk), .rst(rst), .cfg_tx_en(cfg_tx_en), .cfg_divisor(cfg_divisor),
    .cfg_len_m1(cfg_len_m1), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_addr_mode(cfg_addr_mode),
    .cfg_irq_en(cfg_irq_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_addr_bit(wr_addr_bit), .txd(txd), .buf_ready(buf_ready),
    .shift_empty(shift_empty), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int period(input int div);
    return (div == 0) ? 16 : (div + 1) * 8;
  endfunction

  // expected frame from the current configuration
  task automatic build(input logic [7:0] d, input logic a);
    int pos;
    logic p;
    ef = '1; ef[0] = 1'b0; etag[0] = "R2 start";
    p = 1'b0;
    for (int i = 0; i <= int'(cfg_len_m1); i++) begin
      ef[1+i] = d[i]; p = p ^ d[i]; etag[1+i] = "R2 data";
    end
    pos = int'(cfg_len_m1) + 2;
    if (cfg_addr_mode) begin
      ef[pos] = a; p = p ^ a; etag[pos] = "R5 addr"; pos++;
    end
    if (cfg_par_en) begin
      ef[pos] = p ^ cfg_par_odd; etag[pos] = "R4 parity"; pos++;
    end
    et = pos + (cfg_two_stop ? 2 : 1);
    for (int k = pos; k < 13; k++) etag[k] = "R6 stop";
  endtask

  // called at the first negedge of bit k0; returns at the negedge after the frame
  task automatic check_frame(input int k0, input int P);
    for (int k = k0; k < et; k++) begin
      chk(txd == ef[k], etag[k], int'(txd), int'(ef[k]));
      repeat (P - 1) @(negedge clk);
      chk(txd == ef[k], "R3 bit end", int'(txd), int'(ef[k]));
      @(negedge clk);
    end
  endtask

  task automatic write_char(input logic [7:0] d, input logic a);
    wr_valid = 1'b1; wr_data = d; wr_addr_bit = a;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    chk(buf_ready == 1'b1, "R1 reset buf_ready", int'(buf_ready), 1);
    chk(shift_empty == 1'b1, "R1 reset shift_empty", int'(shift_empty), 1);
    chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
    cfg_tx_en = 1'b1;
    @(negedge clk);

    // sweep of every format with three divisor values
    for (int idx = 0; idx < 128; idx++) begin
      logic [7:0] d;
      logic a;
      int dv;
      dv = idx % 3;
      d = 8'((idx * 73 + 29) & 255);
      a = idx[0] ^ idx[3];
      cfg_len_m1 = idx[2:0]; cfg_par_en = idx[3]; cfg_par_odd = idx[4];
      cfg_two_stop = idx[5]; cfg_addr_mode = idx[6];
      cfg_divisor = 16'(dv);
      build(d, a);
      write_char(d, a);
      chk(buf_ready == 1'b0, "R7 buf_ready after write", int'(buf_ready), 0);
      chk(txd == 1'b1, "R7 no start yet", int'(txd), 1);
      @(negedge clk);
      chk(buf_ready == 1'b1, "R7 buf_ready after transfer", int'(buf_ready), 1);
      check_frame(0, period(dv));
      chk(txd == 1'b1, "R1 idle after frame", int'(txd), 1);
      chk(shift_empty == 1'b1, "R8 empty after frame", int'(shift_empty), 1);
    end

    // longer bit periods
    cfg_len_m1 = 3'd7; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    cfg_two_stop = 1'b1; cfg_addr_mode = 1'b0;
    cfg_divisor = 16'd9;
    build(8'hC3, 1'b0);
    write_char(8'hC3, 1'b0);
    @(negedge clk);
    check_frame(0, 80);
    cfg_divisor = 16'd3;
    build(8'h96, 1'b0);
    write_char(8'h96, 1'b0);
    @(negedge clk);
    check_frame(0, 32);

    // back-to-back, overfull write
    begin
      int eta;
      cfg_divisor = 16'd0; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
      build(8'h5A, 1'b0);
      eta = et;
      write_char(8'h5A, 1'b0);
      @(negedge clk);
      chk(txd == 1'b0, "R2 first frame start", int'(txd), 0);
      write_char(8'h3C, 1'b0);
      chk(buf_ready == 1'b0, "R7 second char held", int'(buf_ready), 0);
      chk(shift_empty == 1'b0, "R8 not empty while busy", int'(shift_empty), 0);
      write_char(8'hFF, 1'b1);
      chk(buf_ready == 1'b0, "R10 still full", int'(buf_ready), 0);
      repeat (eta * 16 - 3) @(negedge clk);
      chk(txd == 1'b1, "R9 last stop of first", int'(txd), 1);
      @(negedge clk);
      chk(buf_ready == 1'b1, "R9 second moved", int'(buf_ready), 1);
      build(8'h3C, 1'b0);
      check_frame(0, 16);
      chk(txd == 1'b1, "R10 ignored char not sent", int'(txd), 1);
      chk(shift_empty == 1'b1, "R10 path empty", int'(shift_empty), 1);
      repeat (48) @(negedge clk);
      chk(txd == 1'b1, "R10 line stays idle", int'(txd), 1);
    end

    // disabled transmitter holds a written char
    cfg_tx_en = 1'b0;
    build(8'hA5, 1'b0);
    write_char(8'hA5, 1'b0);
    repeat (50) @(negedge clk);
    chk(txd == 1'b1, "R11 no start while disabled", int'(txd), 1);
    chk(buf_ready == 1'b0, "R11 write accepted", int'(buf_ready), 0);
    chk(shift_empty == 1'b0, "R11 not empty", int'(shift_empty), 0);
    cfg_tx_en = 1'b1;
    @(negedge clk);
    check_frame(0, 16);

    // disable mid-frame: frame completes, next char waits
    build(8'h71, 1'b0);
    write_char(8'h71, 1'b0);
    @(negedge clk);
    repeat (2 * 16) @(negedge clk);
    cfg_tx_en = 1'b0;
    write_char(8'h0E, 1'b0);
    repeat (16 - 1) @(negedge clk);
    check_frame(3, 16);
    chk(txd == 1'b1, "R11 stopped after frame", int'(txd), 1);
    chk(buf_ready == 1'b0, "R11 next char waiting", int'(buf_ready), 0);
    repeat (40) @(negedge clk);
    chk(txd == 1'b1, "R11 still idle", int'(txd), 1);
    build(8'h0E, 1'b0);
    cfg_tx_en = 1'b1;
    @(negedge clk);
    check_frame(0, 16);

    // interrupt
    cfg_irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq with room", int'(irq), 1);
    build(8'h11, 1'b0);
    write_char(8'h11, 1'b0);
    chk(irq == 1'b0, "R12 irq low when full", int'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq after transfer", int'(irq), 1);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R12 irq disabled", int'(irq), 0);
    repeat (et * 16) @(negedge clk);
    chk(shift_empty == 1'b1, "R8 empty at end", int'(shift_empty), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule